// File: doc/BRIEF.md
# Sixteen-bit host to DWORD bridge

This block sits between a 16-bit host data bus and an internal 32-bit register and data-port interface. Every host access moves one half-word, qualified by a single-cycle valid pulse. Address bit 1 selects the half: 0 means bits 15:0 and 1 means bits 31:16. The address bits from bit 2 upward name the DWORD. Two accesses make up one 32-bit transfer, one access to each half of the same DWORD, and the host may access either half first.

On the write side, the first half-word is held in a buffer. The bridge issues one internal write only when the opposite half of the same DWORD arrives. On the read side, the first read of a pair fetches the whole word with one internal read strobe and keeps it in a latch. The second read is served from that latch, so a port with read side effects is popped only once per DWORD.

Some sequences break the pairing: a second access to the same half, a change of DWORD, or a change from read to write or back. Each of these clears the tracking. A write that gets dropped, or a read whose data is invalid, raises a one-cycle error pulse. Normal operation then carries on without further action.

Top module: `hb16_dword_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_stb`, `rd_stb`, `hb_err` and `hb_rvalid` are low.
- R2: A write to one half followed by a write to the other half of the same DWORD produces, in the cycle after the second write, a one-cycle `wr_stb`. In that cycle `wr_addr` equals the DWORD address (`hb_addr` bits from 2 upward), and `wr_data` holds the high-half data in bits 31:16 and the low-half data in bits 15:0. Either order is accepted.
- R3: The first write of a pair issues no `wr_stb`.
- R4: A write to the same half as the pending write of the same DWORD pulses `hb_err` for one cycle and issues no `wr_stb`. Both half-words are discarded, and the next write starts a new pair.
- R5: A read that starts a pair raises `rd_stb` combinationally in its own cycle, with `rd_addr` set to the DWORD address. The bridge latches `rd_data` from that cycle. In the next cycle `hb_rvalid` is high and `hb_rdata` carries the half selected by address bit 1.
- R6: A read of the other half of the same DWORD, following a pair-starting read, raises no `rd_stb`. In the next cycle it returns the other half of the latched word with `hb_rvalid` high.
- R7: A read of the same half as the pending read of the same DWORD pulses `hb_err` and `hb_rvalid` for one cycle, and its data is invalid. The read tracking is cleared, so the next read raises `rd_stb` again.
- R8: An access to a different DWORD than the pending one starts a new pair. If the abandoned pair was a write, `hb_err` pulses; if it was a read, no error is flagged.
- R9: A change of direction while a pair is pending also starts a new pair. A pending write that is abandoned pulses `hb_err`; a pending read that is abandoned does not.
- R10: Without an access (`hb_valid` low), the next cycle shows no `wr_stb`, `rd_stb`, `hb_err` or `hb_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_valid | input | 1 | One-cycle pulse per half-word access |
| hb_write | input | 1 | 1 = write access, 0 = read access |
| hb_addr | input | ADDR_W-1 | Host address bits ADDR_W-1..1; bit 1 selects the half |
| hb_wdata | input | 16 | Half-word write data |
| hb_rdata | output | 16 | Half-word read data, valid with `hb_rvalid` |
| hb_rvalid | output | 1 | Read data valid, one cycle after a read access |
| hb_err | output | 1 | One-cycle pulse on a dropped write or an invalid read |
| wr_stb | output | 1 | Internal 32-bit write strobe |
| wr_addr | output | ADDR_W-2 | Internal DWORD write address |
| wr_data | output | 32 | Assembled 32-bit write data |
| rd_stb | output | 1 | Internal 32-bit read strobe, combinational |
| rd_addr | output | ADDR_W-2 | Internal DWORD read address |
| rd_data | input | 32 | Internal read data, sampled in the `rd_stb` cycle |

## Verification
The hardest condition to reach is an abandoned pair. This needs a pending half combined with a third access that differs from it in exactly one respect: half, DWORD or direction. It also needs the check that the latched read word is not fetched a second time. The bench applies every three-access sequence over two DWORDs, both halves and both directions, starting from reset each time. Its internal data source returns a fetch counter as part of the word, so any extra or missing fetch changes the returned halves.

// File: rtl/hb16_dword_bridge.sv
module hb16_dword_bridge #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_valid,
  input  logic              hb_write,
  input  logic [ADDR_W-1:1] hb_addr,
  input  logic [15:0]       hb_wdata,
  output logic [15:0]       hb_rdata,
  output logic              hb_rvalid,
  output logic              hb_err,
  output logic              wr_stb,
  output logic [ADDR_W-3:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              rd_stb,
  output logic [ADDR_W-3:0] rd_addr,
  input  logic [31:0]       rd_data
);
  localparam int DW_W = ADDR_W - 2;

  logic [DW_W-1:0] acc_dw;
  logic            acc_hi;
  assign acc_dw = hb_addr[ADDR_W-1:2];
  assign acc_hi = hb_addr[1];

  logic            pend_q, pend_wr_q, pend_hi_q;
  logic [DW_W-1:0] pend_dw_q;
  logic [15:0]     wbuf_q;
  logic [31:0]     rlat_q;

  logic match, pair_done, repeat_hit, start, drop_wr;
  assign match      = pend_q & (pend_wr_q == hb_write) & (pend_dw_q == acc_dw);
  assign pair_done  = hb_valid & match & (pend_hi_q != acc_hi);
  assign repeat_hit = hb_valid & match & (pend_hi_q == acc_hi);
  assign start      = hb_valid & ~match;
  assign drop_wr    = start & pend_q & pend_wr_q;

  assign rd_stb  = start & ~hb_write;
  assign rd_addr = acc_dw;

  logic [31:0] word_src;
  logic [15:0] half_out;
  assign word_src = rd_stb ? rd_data : rlat_q;
  assign half_out = acc_hi ? word_src[31:16] : word_src[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_wr_q <= 1'b0;
      pend_hi_q <= 1'b0;
      pend_dw_q <= '0;
      wbuf_q    <= '0;
      rlat_q    <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      hb_err    <= 1'b0;
      hb_rvalid <= 1'b0;
      hb_rdata  <= '0;
    end else begin
      wr_stb    <= pair_done & hb_write;
      hb_err    <= repeat_hit | drop_wr;
      hb_rvalid <= hb_valid & ~hb_write;
      if (pair_done & hb_write) begin
        wr_addr <= acc_dw;
        wr_data <= acc_hi ? {hb_wdata, wbuf_q} : {wbuf_q, hb_wdata};
      end
      if (hb_valid & ~hb_write) hb_rdata <= half_out;
      if (rd_stb) rlat_q <= rd_data;
      if (start & hb_write) wbuf_q <= hb_wdata;
      if (hb_valid) begin
        pend_q    <= start;
        pend_wr_q <= hb_write;
        pend_hi_q <= acc_hi;
        pend_dw_q <= acc_dw;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!wr_stb && !hb_err && !hb_rvalid));

  // R2
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R2
  wr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(hb_valid && hb_write));

  // R4
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_err |-> !wr_stb);

  // R5
  fetch_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> hb_rvalid);

  // R10
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_err || hb_rvalid || wr_stb) |-> $past(hb_valid));

  // R5
  rd_stb_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (hb_valid && !hb_write));
endmodule

// File: tb/hb16_dword_bridge_test.sv
`timescale 1ns/1ps
module hb16_dword_bridge_test;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_valid = 1'b0, hb_write = 1'b0;
  logic [AW-1:1] hb_addr = '0;
  logic [15:0] hb_wdata = '0;
  logic [15:0] hb_rdata;
  logic        hb_rvalid, hb_err, wr_stb, rd_stb;
  logic [AW-3:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [7:0]  pops = 8'd0;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rd_data = {6'b101100, rd_addr, pops, 8'h5A, ~pops};
  always @(posedge clk) if (rd_stb) pops <= pops + 8'd1;

  hb16_dword_bridge #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .hb_valid(hb_valid), .hb_write(hb_write),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .hb_rvalid(hb_rvalid), .hb_err(hb_err), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .rd_data(rd_data));

  bit m_p, m_w, m_h;
  logic [1:0]  m_d;
  logic [15:0] m_buf;
  logic [31:0] m_lat;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hb_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    vectors++;
    // R1
    chk("R1", {wr_stb, rd_stb, hb_err, hb_rvalid}, 4'b0);
    rst_n = 1'b1;
    m_p = 0;
  endtask

  task automatic access(input bit w, input bit h, input logic [1:0] d, input logic [15:0] data);
    bit same, e_err, e_wr, e_rs, e_rv, chk_rd;
    logic [31:0] e_wd;
    logic [15:0] e_rd;
    e_err = 0; e_wr = 0; e_rs = 0; e_rv = !w; chk_rd = 0; e_wd = '0; e_rd = '0;
    same = m_p && (m_w == w) && (m_d == d);
    if (same && m_h != h) begin
      if (w) begin e_wr = 1; e_wd = h ? {data, m_buf} : {m_buf, data}; end
      else begin chk_rd = 1; e_rd = h ? m_lat[31:16] : m_lat[15:0]; end
      m_p = 0;
    end else if (same) begin
      e_err = 1; m_p = 0;
    end else begin
      if (m_p && m_w) e_err = 1;
      m_p = 1; m_w = w; m_h = h; m_d = d;
      if (w) m_buf = data;
      else begin
        e_rs = 1;
        m_lat = {6'b101100, d, pops, 8'h5A, ~pops};
        chk_rd = 1; e_rd = h ? m_lat[31:16] : m_lat[15:0];
      end
    end
    hb_valid = 1'b1; hb_write = w; hb_addr = {d, h}; hb_wdata = data;
    #1;
    vectors++;
    // R5 R6 R7 R8 R9: fetch only on a pair-starting read
    chk(w ? "R8" : (e_rs ? "R5" : "R6"), {31'b0, rd_stb}, {31'b0, e_rs});
    if (e_rs) chk("R5", {30'b0, rd_addr}, {30'b0, d});
    @(negedge clk);
    // R4 R7 R8 R9: error pulse
    chk(w ? "R4" : "R7", {31'b0, hb_err}, {31'b0, e_err});
    // R2 R3: write strobe
    chk(e_wr ? "R2" : "R3", {31'b0, wr_stb}, {31'b0, e_wr});
    if (e_wr) begin
      chk("R2", {30'b0, wr_addr}, {30'b0, d});
      chk("R2", wr_data, e_wd);
    end
    chk("R5", {31'b0, hb_rvalid}, {31'b0, e_rv});
    if (chk_rd) chk(e_rs ? "R5" : "R6", {16'b0, hb_rdata}, {16'b0, e_rd});
  endtask

  task automatic idle();
    hb_valid = 1'b0;
    @(negedge clk);
    vectors++;
    // R10
    chk("R10", {wr_stb, rd_stb, hb_err, hb_rvalid}, 4'b0);
  endtask

  initial begin
    do_reset();
    for (int s = 0; s < 512; s++) begin
      do_reset();
      for (int k = 0; k < 3; k++) begin
        int code;
        code = (s >> (3 * k)) & 7;
        access(code[2], code[1], {1'b0, code[0]}, 16'(s * 7 + k * 16'h1111 + 16'h0A5));
      end
      idle();
    end
    // R7: repeated read, then recovery with a fresh fetch and a good pair
    do_reset();
    access(0, 1, 2'd3, 16'h0);
    access(0, 1, 2'd3, 16'h0);
    access(0, 1, 2'd3, 16'h0);
    access(0, 0, 2'd3, 16'h0);
    idle();
    // R2 R4: repeated write then a clean pair on DWORD 2
    access(1, 0, 2'd2, 16'hBEEF);
    access(1, 0, 2'd2, 16'hCAFE);
    access(1, 1, 2'd2, 16'h1234);
    access(1, 0, 2'd2, 16'h5678);
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule